// File: doc/BRIEF.md
# I2C Write-Only Slave Byte Engine

This block is the serial front end of a register-mapped slave on a two-wire bus. It watches the already synchronised clock and data lines and finds the bus conditions: a start, a stop and a repeated start. It then shifts in bytes most significant bit first. The first byte after a start carries a 7-bit slave address and a direction bit. The engine answers only a matching write. The next byte is handed on as a register pointer. Every byte after that is handed on as data for the register the pointer selects.

Bytes leave the block only after their acknowledge clock has finished. A stop or repeated start that arrives while a byte is still being shifted therefore drops the partial byte. With each data byte the engine also raises an advance strobe. The pointer block uses it to move its pointer in whatever mode it is set to. A repeated start sends the engine back to waiting for an address byte and does not clear the pointer.

Top module: `i2c_wr_slave`

## Requirements
- R1: After synchronous reset, sda_pull, ptr_load, wr_stb and adv_stb are all 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are sampled on SCL rising edges, most significant bit first, so the first bit sent becomes bit 7 of the byte.
- R3: The first byte after a start is acknowledged only when its bits 7..1 equal dev_addr and its bit 0 (direction) is 0. The acknowledge is sda_pull = 1, set while SCL is low after the eighth bit and held through the high phase of the ninth clock.
- R4: When the first byte does not match, or its direction bit is 1, sda_pull stays 0. The engine then ignores every byte until the next start: no acknowledge and no strobe.
- R5: The byte that follows an acknowledged address byte is output on ptr_byte with a one-cycle ptr_load pulse. It is acknowledged.
- R6: Each later byte is output on wr_byte with a one-cycle wr_stb pulse. It is acknowledged, and adv_stb pulses in the same cycle as wr_stb.
- R7: ptr_load and wr_stb fire only after the falling SCL edge that ends the ninth (acknowledge) clock. A stop that comes before a byte is complete produces no strobe for that byte.
- R8: A repeated start in the middle of a data byte discards that byte. The engine then expects an address byte again, and the byte after it produces a new ptr_load.
- R9: sda_pull returns to 0 after the ninth clock's falling edge, before the master drives the next bit. It never changes while SCL is high.
- R10: ptr_load and wr_stb are never high in the same cycle, and each stays high for a single cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| dev_addr | input | ADDR_W | Fixed slave address |
| sda_pull | output | 1 | Drive SDA low when 1 (acknowledge) |
| ptr_load | output | 1 | Register pointer load strobe |
| ptr_byte | output | ADDR_W+1 | Pointer value for ptr_load |
| wr_stb | output | 1 | Data write strobe |
| wr_byte | output | ADDR_W+1 | Data byte for wr_stb |
| adv_stb | output | 1 | Pointer advance strobe |

## Verification
Two actions share one cycle. The commit of a data byte (wr_stb) and the pointer advance (adv_stb) are meant to fall together, so the pointer block writes to the old address before it moves. The bench sends runs of data bytes and counts how many cycles have both strobes high. That count must equal the number of committed bytes. A checker also ties each strobe to the other cycle by cycle. The second coincidence is a bus condition that lands where a byte would be committed. Stops and repeated starts are injected part way through a byte, and the logged strobe count must show that the partial byte never appeared.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CTRL = 2'd1,
    ST_REG  = 2'd2,
    ST_DATA = 2'd3
  } wr_state_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_shift_in.sv
module i2c_shift_in #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   sample,
  input  logic                   bit_in,
  output logic [W-1:0]           data,
  output logic [$clog2(W+1)-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data  <= '0;
      count <= '0;
    end else if (sample) begin
      data  <= {data[W-2:0], bit_in};
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import i2c_wr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_pull,
  output logic              ptr_load,
  output logic [ADDR_W:0]   ptr_byte,
  output logic              wr_stb,
  output logic [ADDR_W:0]   wr_byte,
  output logic              adv_stb
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_data;
  logic [CNT_W-1:0]  rx_cnt;
  logic shift_clr, shift_smp, byte_full, addr_hit;
  wr_state_t state;
  logic ack_ph, ack_ok;

  i2c_line_events u_ev (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign byte_full = (rx_cnt == CNT_W'(BYTE_W));
  assign shift_clr = start_ev | stop_ev | (scl_fall & ack_ph);
  assign shift_smp = scl_rise & (state != ST_IDLE) & ~ack_ph & ~byte_full;

  i2c_shift_in #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst(rst), .clr(shift_clr), .sample(shift_smp),
    .bit_in(sda_i), .data(rx_data), .count(rx_cnt)
  );

  assign addr_hit = (rx_data[BYTE_W-1:1] == dev_addr) & ~rx_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_ph   <= 1'b0;
      ack_ok   <= 1'b0;
      sda_pull <= 1'b0;
      ptr_load <= 1'b0;
      ptr_byte <= '0;
      wr_stb   <= 1'b0;
      wr_byte  <= '0;
      adv_stb  <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      wr_stb   <= 1'b0;
      adv_stb  <= 1'b0;
      if (start_ev) begin
        state    <= ST_CTRL;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        ack_ph   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (scl_fall && state != ST_IDLE) begin
        if (!ack_ph && byte_full) begin
          ack_ph   <= 1'b1;
          ack_ok   <= (state == ST_CTRL) ? addr_hit : 1'b1;
          sda_pull <= (state == ST_CTRL) ? addr_hit : 1'b1;
        end else if (ack_ph) begin
          ack_ph   <= 1'b0;
          sda_pull <= 1'b0;
          unique case (state)
            ST_CTRL: state <= ack_ok ? ST_REG : ST_IDLE;
            ST_REG: begin
              ptr_load <= 1'b1;
              ptr_byte <= rx_data;
              state    <= ST_DATA;
            end
            ST_DATA: begin
              wr_stb  <= 1'b1;
              adv_stb <= 1'b1;
              wr_byte <= rx_data;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_wr_slave_chk.sv
module i2c_wr_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_pull,
  input logic ptr_load,
  input logic wr_stb,
  input logic adv_stb
);
  // R6
  wr_adv_pair_chk: assert property (@(posedge clk) disable iff (rst) wr_stb |-> adv_stb);
  // R6
  adv_wr_pair_chk: assert property (@(posedge clk) disable iff (rst) adv_stb |-> wr_stb);
  // R10
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (rst) !(ptr_load && wr_stb));
  // R10
  wr_single_chk: assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb);
  // R10
  ptr_single_chk: assert property (@(posedge clk) disable iff (rst) ptr_load |=> !ptr_load);
  // R3
  ack_on_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(sda_pull) |-> !scl_i);
  // R9
  ack_off_low_chk: assert property (@(posedge clk) disable iff (rst) $fell(sda_pull) |-> !scl_i);
endmodule

bind i2c_wr_slave i2c_wr_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull(sda_pull),
  .ptr_load(ptr_load), .wr_stb(wr_stb), .adv_stb(adv_stb)
);

// File: tb/i2c_wr_slave_test.sv
module i2c_wr_slave_test;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pull, ptr_load, wr_stb, adv_stb;
  logic [7:0] ptr_byte, wr_byte;

  int errs = 0, checks = 0;
  int ptr_n = 0, wr_n = 0, adv_n = 0, both_n = 0;
  logic [7:0] ptr_log [16];
  logic [7:0] wr_log [16];
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_wr_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .dev_addr(DEV),
    .sda_pull(sda_pull), .ptr_load(ptr_load), .ptr_byte(ptr_byte),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .adv_stb(adv_stb)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (ptr_load) begin ptr_log[ptr_n[3:0]] <= ptr_byte; ptr_n <= ptr_n + 1; end
      if (wr_stb)   begin wr_log[wr_n[3:0]] <= wr_byte; wr_n <= wr_n + 1; end
      if (adv_stb) adv_n <= adv_n + 1;
      if (wr_stb && adv_stb) both_n <= both_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(Q);
    sda_m = 0; wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    scl_m = 0; sda_m = 0; wq(Q);
    scl_m = 1; wq(Q);
    sda_m = 1; wq(Q);
  endtask

  task automatic bus_restart();
    scl_m = 0; sda_m = 1; wq(Q);
    scl_m = 1; wq(Q);
    sda_m = 0; wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wq(Q);
      scl_m = 1; wq(2*Q);
      scl_m = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    send_bits(b, 8);
    sda_m = 1; wq(Q);
    scl_m = 1; wq(Q);
    ack = !sda_line;
    wq(Q);
    scl_m = 0; wq(Q);
    rel = !sda_pull;
  endtask

  task automatic t_reset();
    chk(!sda_pull, "R1", sda_pull, 0);
    chk(!ptr_load && !wr_stb && !adv_stb, "R1", {ptr_load, wr_stb, adv_stb}, 0);
  endtask

  task automatic t_basic();
    bit a, r;
    int p0 = ptr_n, w0 = wr_n, b0 = both_n;
    bus_start();
    send_byte({DEV, 1'b0}, a, r); chk(a, "R3", a, 1); chk(r, "R9", !r, 0);
    send_byte(8'h12, a, r);       chk(a, "R5", a, 1);
    chk(ptr_n == p0 + 1 && ptr_log[p0[3:0]] == 8'h12, "R5", ptr_log[p0[3:0]], 8'h12);
    send_byte(8'hA5, a, r);       chk(a, "R6", a, 1); chk(r, "R9", !r, 0);
    send_byte(8'h3C, a, r);       chk(a, "R6", a, 1);
    bus_stop();
    chk(wr_n == w0 + 2, "R6", wr_n - w0, 2);
    chk(wr_log[w0[3:0]] == 8'hA5, "R2", wr_log[w0[3:0]], 8'hA5);
    chk(wr_log[w0[3:0]+1] == 8'h3C, "R2", wr_log[w0[3:0]+1], 8'h3C);
    chk(both_n == b0 + 2 && adv_n == both_n, "R6", both_n - b0, 2);
  endtask

  task automatic t_wrong_addr();
    bit a, r;
    int p0 = ptr_n, w0 = wr_n;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a, r); chk(!a, "R4", a, 0);
    send_byte(8'h04, a, r);               chk(!a, "R4", a, 0);
    send_byte(8'h55, a, r);               chk(!a, "R4", a, 0);
    bus_stop();
    chk(ptr_n == p0 && wr_n == w0, "R4", ptr_n - p0 + wr_n - w0, 0);
  endtask

  task automatic t_read_bit();
    bit a, r;
    int p0 = ptr_n;
    bus_start();
    send_byte({DEV, 1'b1}, a, r); chk(!a, "R4", a, 0);
    send_byte(8'h06, a, r);       chk(!a, "R4", a, 0);
    bus_stop();
    chk(ptr_n == p0, "R4", ptr_n - p0, 0);
  endtask

  task automatic t_stop_mid();
    bit a, r;
    int w0 = wr_n;
    bus_start();
    send_byte({DEV, 1'b0}, a, r);
    send_byte(8'h01, a, r);
    send_byte(8'h11, a, r);
    send_bits(8'hF0, 4);
    bus_stop();
    chk(wr_n == w0 + 1, "R7", wr_n - w0, 1);
    chk(wr_log[w0[3:0]] == 8'h11, "R7", wr_log[w0[3:0]], 8'h11);
  endtask

  task automatic t_restart();
    bit a, r;
    int w0 = wr_n, p0 = ptr_n;
    bus_start();
    send_byte({DEV, 1'b0}, a, r);
    send_byte(8'h05, a, r);
    send_byte(8'h77, a, r);
    send_bits(8'hC3, 5);
    bus_restart();
    chk(wr_n == w0 + 1, "R8", wr_n - w0, 1);
    send_byte({DEV, 1'b0}, a, r); chk(a, "R8", a, 1);
    chk(ptr_n == p0 + 1, "R8", ptr_n - p0, 1);
    send_byte(8'h09, a, r);
    chk(ptr_n == p0 + 2 && ptr_log[p0[3:0]+1] == 8'h09, "R8", ptr_log[p0[3:0]+1], 8'h09);
    bus_stop();
    chk(wr_n == w0 + 1, "R8", wr_n - w0, 1);
  endtask

  initial begin
    wq(5);
    t_reset();
    rst = 0;
    wq(5);
    t_basic();
    t_wrong_addr();
    t_read_bit();
    t_stop_mid();
    t_restart();
    t_basic();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule